// File: doc/BRIEF.md
# Neighborhood Shift Register Template Matcher

This block is a row of identical one-bit slices, one per pixel column of a binary image line. Each slice keeps a bank of five-cell vertical shift registers and a smaller bank of plain one-bit registers. When a line is written into a shift register, every slice pushes its pixel in at the south end and moves the older lines one place north. After two further lines have been written, the middle cell holds the current pixel and the outer cells hold the two lines above it and the two lines below it.

On a match strobe, every slice builds a nine-tap cross around its current pixel from the selected register. Two taps lie north and two lie south, taken from the slice's own chain. Two taps lie east and two lie west, taken from the middle cells of the adjacent slices. The cross is compared against a shared three-valued template, and the slice registers one result bit. Morphological steps such as erosion, dilation and hit-or-miss detection are built by issuing a sequence of such matches.

Top module: `nbr_match_array`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `result` and `result_valid` are 0. All register cells are cleared, so a match with every position set to must-be-0 returns all ones.
- R2: A load to a shift register (select value below NREG) does two things in one clock. It writes `line_in[i]` into cell 0 (south-2) of slice i, and it moves each cell k to cell k+1. Cell 4 is discarded.
- R3: The vertical taps of a shift register are fixed by cell number. The center is cell 2. North-1 is cell 3 and north-2 is cell 4, which are the older lines. South-1 is cell 1 and south-2 is cell 0, which are the newer lines.
- R4: A load to a plain register (select value from NREG up to NREG+NPLAIN-1) overwrites its bit directly and does not shift. When a plain register is matched, its bit is the center, and all four vertical taps read 0.
- R5: East-1 and east-2 of slice i are the center values of slices i+1 and i+2, taken from the same selected register. West-1 and west-2 are the center values of slices i-1 and i-2.
- R6: An east or west tap that falls outside the array reads 0.
- R7: The template `tmpl` holds a two-bit field per position p at bits [2p+1:2p]. The positions are 0 center, 1 north-1, 2 north-2, 3 south-1, 4 south-2, 5 east-1, 6 east-2, 7 west-1 and 8 west-2. The upper bit of a field is "care" and the lower bit is the required value, so 1x means the tap must equal x and 0x means don't-care. A slice returns 1 exactly when every cared position agrees.
- R8: `result` is updated only at the clock edge that samples `match_en` high, and it holds at every other edge. `result_valid` is high exactly in the cycle after an accepted `match_en`.
- R9: When a load and a match arrive in the same cycle, the match uses the register contents from before that load.
- R10: A load changes only the selected register. All other registers keep their contents.
- R11: A select value at or above NREG+NPLAIN ignores loads. A match with such a select value sees every tap as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write `line_in` into the selected register |
| sel | input | SELW | Register select for load and match |
| line_in | input | NSLICE | One pixel per slice for a load |
| match_en | input | 1 | Evaluate the template on the selected register |
| tmpl | input | 18 | Nine two-bit template fields |
| result | output | NSLICE | Registered match bit per slice |
| result_valid | output | 1 | High in the cycle after an accepted match |

## Verification
The cells can only be seen through matches, so a fault in the stored state appears only in the `result` cycle that follows a strobe. The bench therefore sweeps every single-care template over the selected register after each load. Each sweep probes one tap at a time: a swapped cell, a missed shift, a wrong neighbor index or a stale edge value flips the bits of the affected slices in the first sweep after the fault.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  localparam int NPOS   = 9;
  localparam int TMPL_W = 2 * NPOS;
  localparam int CHAIN  = 5;

  // template position indices (field of position p at [2p+1:2p])
  localparam int P_C  = 0;
  localparam int P_N1 = 1;
  localparam int P_N2 = 2;
  localparam int P_S1 = 3;
  localparam int P_S2 = 4;
  localparam int P_E1 = 5;
  localparam int P_E2 = 6;
  localparam int P_W1 = 7;
  localparam int P_W2 = 8;

  // chain cell order: bit 0 newest (south-2) up to bit 4 oldest (north-2)
  typedef struct packed {
    logic n2;
    logic n1;
    logic c;
    logic s1;
    logic s2;
  } vtaps_t;
endpackage

// File: rtl/nbr_slice_bank.sv
module nbr_slice_bank
  import nbr_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int NPLAIN = 48,
  parameter int SELW   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_en,
  input  logic [SELW-1:0] sel,
  input  logic            pix_in,
  output vtaps_t          taps
);
  localparam int NTOT = NREG + NPLAIN;

  logic [CHAIN-1:0] chain [NREG];
  logic [(NPLAIN > 0 ? NPLAIN : 1)-1:0] plain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) chain[r] <= '0;
    end else if (load_en) begin
      for (int r = 0; r < NREG; r++)
        if (int'(sel) == r) chain[r] <= {chain[r][CHAIN-2:0], pix_in};
    end
  end

  generate
    if (NPLAIN > 0) begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) plain <= '0;
        else if (load_en) begin
          for (int p = 0; p < NPLAIN; p++)
            if (int'(sel) == NREG + p) plain[p] <= pix_in;
        end
      end
    end else begin : g_noplain
      always_ff @(posedge clk) plain <= '0;
    end
  endgenerate

  always_comb begin
    taps = '0;
    for (int r = 0; r < NREG; r++)
      if (int'(sel) == r) taps = vtaps_t'(chain[r]);
    for (int p = 0; p < NPLAIN; p++)
      if (int'(sel) == NREG + p) taps.c = plain[p];
    if (int'(sel) >= NTOT) taps = '0;
  end
endmodule

// File: rtl/nbr_tmpl_cmp.sv
module nbr_tmpl_cmp
  import nbr_pkg::*;
(
  input  logic [NPOS-1:0]   tap_vec,
  input  logic [TMPL_W-1:0] tmpl,
  output logic              hit
);
  logic [NPOS-1:0] agree;

  generate
    for (genvar p = 0; p < NPOS; p++) begin : g_pos
      assign agree[p] = ~tmpl[2*p+1] | (tmpl[2*p] == tap_vec[p]);
    end
  endgenerate

  assign hit = &agree;
endmodule

// File: rtl/nbr_match_array.sv
module nbr_match_array
  import nbr_pkg::*;
#(
  parameter int NSLICE = 32,
  parameter int NREG   = 16,
  parameter int NPLAIN = 48,
  localparam int SELW  = $clog2(NREG + NPLAIN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_en,
  input  logic [SELW-1:0]     sel,
  input  logic [NSLICE-1:0]   line_in,
  input  logic                match_en,
  input  logic [TMPL_W-1:0]   tmpl,
  output logic [NSLICE-1:0]   result,
  output logic                result_valid
);
  localparam int PAD = 2;

  vtaps_t                    vt  [NSLICE];
  logic [NSLICE-1:0]         ctr;
  logic [NSLICE+2*PAD-1:0]   ctr_pad;
  logic [NSLICE-1:0]         hit;

  assign ctr_pad = {{PAD{1'b0}}, ctr, {PAD{1'b0}}};

  generate
    for (genvar i = 0; i < NSLICE; i++) begin : g_slice
      logic [NPOS-1:0] tv;

      nbr_slice_bank #(.NREG(NREG), .NPLAIN(NPLAIN), .SELW(SELW)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .load_en(load_en),
        .sel    (sel),
        .pix_in (line_in[i]),
        .taps   (vt[i])
      );

      assign ctr[i]   = vt[i].c;
      assign tv[P_C]  = vt[i].c;
      assign tv[P_N1] = vt[i].n1;
      assign tv[P_N2] = vt[i].n2;
      assign tv[P_S1] = vt[i].s1;
      assign tv[P_S2] = vt[i].s2;
      assign tv[P_E1] = ctr_pad[i+PAD+1];
      assign tv[P_E2] = ctr_pad[i+PAD+2];
      assign tv[P_W1] = ctr_pad[i+PAD-1];
      assign tv[P_W2] = ctr_pad[i+PAD-2];

      nbr_tmpl_cmp u_cmp (
        .tap_vec(tv),
        .tmpl   (tmpl),
        .hit    (hit[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= match_en;
      if (match_en) result <= hit;
    end
  end
endmodule

// File: rtl/nbr_match_checker.sv
module nbr_match_checker
  import nbr_pkg::*;
#(
  parameter int NSLICE = 32,
  parameter int NREG   = 16,
  parameter int NPLAIN = 48,
  parameter int SELW   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [SELW-1:0]   sel,
  input logic              match_en,
  input logic [TMPL_W-1:0] tmpl,
  input logic [NSLICE-1:0] result,
  input logic              result_valid
);
  logic [NPOS-1:0] care;
  logic            is_plain;

  always_comb begin
    for (int p = 0; p < NPOS; p++) care[p] = tmpl[2*p+1];
  end
  assign is_plain = (int'(sel) >= NREG) && (int'(sel) < NREG + NPLAIN);

  // R1
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (result == '0 && !result_valid));

  // R8
  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (rst)
    match_en |=> result_valid);
  assert_valid_low_R8: assert property (@(posedge clk) disable iff (rst)
    !match_en |=> !result_valid);
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !match_en |=> $stable(result));

  // R7
  assert_dontcare_all_R7: assert property (@(posedge clk) disable iff (rst)
    (match_en && care == '0) |=> (result == '1));

  // R6
  assert_east_edge_R6: assert property (@(posedge clk) disable iff (rst)
    (match_en && tmpl[2*P_E1+1 -: 2] == 2'b11) |=> !result[NSLICE-1]);
  assert_west_edge_R6: assert property (@(posedge clk) disable iff (rst)
    (match_en && tmpl[2*P_W1+1 -: 2] == 2'b11) |=> !result[0]);

  // R4
  assert_plain_no_vertical_R4: assert property (@(posedge clk) disable iff (rst)
    (match_en && is_plain && tmpl[2*P_N1+1 -: 2] == 2'b11) |=> (result == '0));
endmodule

bind nbr_match_array nbr_match_checker #(
  .NSLICE(NSLICE), .NREG(NREG), .NPLAIN(NPLAIN), .SELW(SELW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sel         (sel),
  .match_en    (match_en),
  .tmpl        (tmpl),
  .result      (result),
  .result_valid(result_valid)
);

// File: tb/tb_nbr_match_array.sv
`timescale 1ns/1ps
module tb_nbr_match_array;
  localparam int NS = 6;
  localparam int NR = 2;
  localparam int NP = 1;
  localparam int SW = $clog2(NR + NP);
  localparam int TW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_en = 1'b0;
  logic [SW-1:0] sel = '0;
  logic [NS-1:0] line_in = '0;
  logic          match_en = 1'b0;
  logic [TW-1:0] tmpl = '0;
  logic [NS-1:0] result;
  logic          result_valid;

  int n_chk = 0;
  int n_bad = 0;

  bit mdl_nb [NR][NS][5];
  bit mdl_pl [NP][NS];

  always #2 clk = ~clk;

  nbr_match_array #(.NSLICE(NS), .NREG(NR), .NPLAIN(NP)) dut (
    .clk(clk), .rst(rst), .load_en(load_en), .sel(sel), .line_in(line_in),
    .match_en(match_en), .tmpl(tmpl), .result(result), .result_valid(result_valid)
  );

  task automatic chk(string req, logic [NS-1:0] act, logic [NS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic bit center_of(int s, int i);
    if (i < 0 || i >= NS) return 1'b0;
    if (s < NR) return mdl_nb[s][i][2];
    if (s < NR + NP) return mdl_pl[s-NR][i];
    return 1'b0;
  endfunction

  function automatic bit cell_of(int s, int i, int c);
    if (s < NR) return mdl_nb[s][i][c];
    return 1'b0;
  endfunction

  function automatic logic [NS-1:0] expect_res(int s, logic [TW-1:0] t);
    logic [NS-1:0] r;
    bit tap [9];
    for (int i = 0; i < NS; i++) begin
      tap[0] = center_of(s, i);
      tap[1] = cell_of(s, i, 3);
      tap[2] = cell_of(s, i, 4);
      tap[3] = cell_of(s, i, 1);
      tap[4] = cell_of(s, i, 0);
      tap[5] = center_of(s, i + 1);
      tap[6] = center_of(s, i + 2);
      tap[7] = center_of(s, i - 1);
      tap[8] = center_of(s, i - 2);
      r[i] = 1'b1;
      for (int p = 0; p < 9; p++)
        if (t[2*p+1] && (t[2*p] != tap[p])) r[i] = 1'b0;
    end
    return r;
  endfunction

  task automatic model_load(int s, logic [NS-1:0] ln);
    for (int i = 0; i < NS; i++) begin
      if (s < NR) begin
        for (int c = 4; c > 0; c--) mdl_nb[s][i][c] = mdl_nb[s][i][c-1];
        mdl_nb[s][i][0] = ln[i];
      end else if (s < NR + NP) begin
        mdl_pl[s-NR][i] = ln[i];
      end
    end
  endtask

  task automatic do_load(int s, logic [NS-1:0] ln);
    @(negedge clk);
    load_en = 1'b1; sel = SW'(s); line_in = ln; match_en = 1'b0;
    @(negedge clk);
    load_en = 1'b0;
    model_load(s, ln);
  endtask

  task automatic do_match(int s, logic [TW-1:0] t, string req);
    logic [NS-1:0] exp;
    @(negedge clk);
    match_en = 1'b1; sel = SW'(s); tmpl = t;
    exp = expect_res(s, t);
    @(negedge clk);
    match_en = 1'b0;
    chk(req, result, exp);
    chk({req, " valid R8"}, {{(NS-1){1'b0}}, result_valid}, {{(NS-1){1'b0}}, 1'b1});
  endtask

  task automatic sweep(int s, string req);
    logic [TW-1:0] t;
    for (int p = 0; p < 9; p++) begin
      for (int v = 0; v < 2; v++) begin
        t = '0; t[2*p+1] = 1'b1; t[2*p] = v[0];
        do_match(s, t, req);
      end
    end
    for (int k = 0; k < 4; k++) do_match(s, TW'($urandom), {req, " R7"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [NS-1:0] held;
    logic [NS-1:0] exp;
    logic [NS-1:0] ln;
    repeat (3) @(negedge clk);
    chk("R1 reset result", result, '0);
    chk("R1 reset valid", {{(NS-1){1'b0}}, result_valid}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", result, '0);
    do_match(0, {9{2'b10}}, "R1 cleared cells");
    do_match(NR, {9{2'b10}}, "R1 cleared plain");

    // R2 R3 R5 R6 R7: fill reg 0 one line at a time, probing every tap
    for (int n = 0; n < 6; n++) begin
      do_load(0, NS'($urandom));
      sweep(0, "R2 R3 R5 R6 shift reg0");
    end
    do_load(0, '1);
    do_match(0, {2'b11, 16'b0}, "R6 W2 edge");
    do_match(0, {4'b0, 2'b11, 12'b0}, "R6 E2 edge");

    // R10: loads into reg 1 leave reg 0 untouched
    for (int n = 0; n < 3; n++) do_load(1, NS'($urandom));
    sweep(1, "R3 reg1");
    sweep(0, "R10 reg0 kept");

    // R4: plain register overwrites without shifting
    do_load(NR, NS'($urandom));
    do_load(NR, NS'($urandom));
    sweep(NR, "R4 plain");
    sweep(1, "R10 reg1 kept");

    // R11: out-of-range select
    do_load(NR + NP, '1);
    sweep(NR + NP, "R11 out of range");
    sweep(0, "R11 reg0 kept");
    sweep(NR, "R11 plain kept");

    // R9: load and match in the same cycle
    ln = NS'($urandom);
    @(negedge clk);
    load_en = 1'b1; match_en = 1'b1; sel = '0; line_in = ln;
    tmpl = {2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11};
    exp = expect_res(0, tmpl);
    @(negedge clk);
    load_en = 1'b0; match_en = 1'b0;
    model_load(0, ln);
    chk("R9 pre-load view", result, exp);
    sweep(0, "R9 post-load state");

    // R8: result holds without a strobe
    held = result;
    repeat (3) begin
      @(negedge clk);
      chk("R8 hold", result, held);
      chk("R8 valid low", {{(NS-1){1'b0}}, result_valid}, '0);
    end
    do_load(0, ~result);
    chk("R8 hold over load", result, held);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule